// File: doc/BRIEF.md
# Software CPU Reset Control Register

This block is an 8-bit control register at one fixed I/O port address. Software writes it to ask for a processor reset of one of three kinds: a soft reset (INIT# pulse only), a hard reset (RESET# pulse), or a hard reset that also starts the processor's built-in self-test. In the self-test case INIT# stays asserted after RESET# is released. The same register also holds a deturbo enable, which goes straight out to the clock throttling logic.

A reset sequence starts only when a write sets the request bit from 0 to 1. The kind of reset is taken from the value written in that same write. While a sequence runs, a busy flag is high and further requests are dropped. The pulse lengths are parameters.

Top module: `srst_ctrl`

## Requirements
- R1: After reset the register reads 00h, RESET# (`cpu_reset_n`) and INIT# (`cpu_init_n`) are high, and `busy` and `deturbo` are low.
- R2: A write at `io_addr == PORT_ADDR` stores `io_wdata[3:0]`. A read at that address returns the stored bits in [3:0] and 0 in [7:4]. At any other address, reads return 00h and writes change nothing.
- R3: A sequence starts only on a write that takes bit 2 (reset request) from 0 to 1. A write of bit 2 = 1 while the stored bit 2 is already 1 starts nothing.
- R4: With bit 3 = 0 and bit 1 = 0 in the starting write, INIT# is low for exactly SOFT_LEN cycles and RESET# stays high.
- R5: With bit 3 = 0 and bit 1 = 1 (hard), RESET# is low for exactly HARD_LEN cycles and INIT# stays high.
- R6: With bit 3 = 1 (self-test), bit 1 is ignored. RESET# is low for HARD_LEN cycles, and INIT# is low in those same cycles and for BIST_LEN further cycles after RESET# rises.
- R7: Bit 0 (deturbo) drives the `deturbo` output from the cycle after the write. A rising edge of bit 2 in a write that also has bit 0 = 1 starts no sequence.
- R8: `busy` is high in every cycle of a sequence and low otherwise. Rising edges of bit 2 while `busy` is high start nothing and do not lengthen the running sequence.
- R9: The reset kind is fixed at the starting write. Changing bits 3 and 1 during a sequence does not change its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| cpu_reset_n | output | 1 | Processor RESET#, active low |
| cpu_init_n | output | 1 | Processor INIT#, active low |
| deturbo | output | 1 | Deturbo enable |
| busy | output | 1 | A reset sequence is running |

## Verification
Some rules are checked by assertions on every cycle:
- a sequence begins only in the cycle after an accepted request, and never with deturbo set;
- the phase counter counts down without restarting while busy;
- at the release of RESET#, INIT# is low exactly when the self-test option was captured;
- both reset outputs are idle whenever `busy` is low.

The exact pulse lengths of each reset kind, the rejection of repeated and deturbo-blocked requests, the read masking and address decode, and the capture of the mode at the starting write can only be shown by the bench scenarios. The bench counts output cycles over a full window after each stimulus.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned FLD_W = 4;
  localparam int unsigned B_DTURBO = 0;
  localparam int unsigned B_HARD   = 1;
  localparam int unsigned B_REQ    = 2;
  localparam int unsigned B_SELFT  = 3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SOFT = 2'd1,
    SQ_HARD = 2'd2,
    SQ_HOLD = 2'd3
  } seq_state_t;
endpackage

// File: rtl/srst_rsync.sv
module srst_rsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/srst_regfile.sv
module srst_regfile
  import srst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0C80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [REG_W-1:0]  io_wdata,
  input  logic              busy,
  output logic [REG_W-1:0]  io_rdata,
  output logic              start,
  output logic              start_hard,
  output logic              start_selft,
  output logic              deturbo
);
  logic [FLD_W-1:0] ctl_q, ctl_d;
  logic             hit, wr_hit, ctl_en;
  logic             req_rise;

  assign hit    = (io_addr == PORT_ADDR);
  assign wr_hit = io_wr && hit;
  assign ctl_en = wr_hit;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_en) ctl_d = io_wdata[FLD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  // Request edge: stored bit low, written bit high.
  assign req_rise    = wr_hit && !ctl_q[B_REQ] && io_wdata[B_REQ];
  assign start       = req_rise && !io_wdata[B_DTURBO] && !busy;
  assign start_hard  = io_wdata[B_HARD];
  assign start_selft = io_wdata[B_SELFT];

  assign deturbo  = ctl_q[B_DTURBO];
  assign io_rdata = hit ? {{(REG_W-FLD_W){1'b0}}, ctl_q} : '0;
endmodule

// File: rtl/srst_seq.sv
module srst_seq
  import srst_pkg::*;
#(
  parameter int unsigned SOFT_LEN = 4,
  parameter int unsigned HARD_LEN = 8,
  parameter int unsigned BIST_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_hard,
  input  logic start_selft,
  output logic cpu_reset_n,
  output logic cpu_init_n,
  output logic busy
);
  localparam int unsigned MAX_AB  = (SOFT_LEN > HARD_LEN) ? SOFT_LEN : HARD_LEN;
  localparam int unsigned MAX_LEN = (MAX_AB > BIST_LEN) ? MAX_AB : BIST_LEN;
  localparam int unsigned CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [CNT_W-1:0] SOFT_LD = CNT_W'(SOFT_LEN - 1);
  localparam logic [CNT_W-1:0] HARD_LD = CNT_W'(HARD_LEN - 1);
  localparam logic [CNT_W-1:0] BIST_LD = CNT_W'(BIST_LEN - 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             selft_q, selft_d;
  logic             rst_out_q, rst_out_d;
  logic             init_out_q, init_out_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    selft_d = selft_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          selft_d = start_selft;
          if (start_selft || start_hard) begin
            st_d  = SQ_HARD;
            cnt_d = HARD_LD;
          end else begin
            st_d  = SQ_SOFT;
            cnt_d = SOFT_LD;
          end
        end
      end
      SQ_SOFT: begin
        if (last) st_d = SQ_IDLE;
        else      cnt_d = cnt_q - 1'b1;
      end
      SQ_HARD: begin
        if (last) begin
          if (selft_q) begin
            st_d  = SQ_HOLD;
            cnt_d = BIST_LD;
          end else begin
            st_d = SQ_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_HOLD: begin
        if (last) st_d = SQ_IDLE;
        else      cnt_d = cnt_q - 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // Outputs are registered from the next state so the pins never glitch.
  always_comb begin
    rst_out_d  = (st_d != SQ_HARD);
    init_out_d = !((st_d == SQ_SOFT) || (st_d == SQ_HOLD) ||
                   ((st_d == SQ_HARD) && selft_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      cnt_q      <= '0;
      selft_q    <= 1'b0;
      rst_out_q  <= 1'b1;
      init_out_q <= 1'b1;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      selft_q    <= selft_d;
      rst_out_q  <= rst_out_d;
      init_out_q <= init_out_d;
    end
  end

  assign cpu_reset_n = rst_out_q;
  assign cpu_init_n  = init_out_q;
  assign busy        = (st_q != SQ_IDLE);

  // R8: a running phase counts down by one and never restarts
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE && !last) |=> (st_q == $past(st_q) && cnt_q == $past(cnt_q) - 1'b1));

  // R6: when RESET# is released, INIT# is still low only for self-test
  p_init_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset_n) |-> (cpu_init_n == !selft_q));

  // R1: both reset pins idle whenever no sequence runs
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cpu_reset_n && cpu_init_n));
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0C80,
  parameter int unsigned SOFT_LEN  = 4,
  parameter int unsigned HARD_LEN  = 8,
  parameter int unsigned BIST_LEN  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cpu_reset_n,
  output logic              cpu_init_n,
  output logic              deturbo,
  output logic              busy
);
  logic rst_s_n;
  logic start_w, hard_w, selft_w;

  srst_rsync #(.STAGES(2)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  srst_regfile #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_regs (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .busy        (busy),
    .io_rdata    (io_rdata),
    .start       (start_w),
    .start_hard  (hard_w),
    .start_selft (selft_w),
    .deturbo     (deturbo)
  );

  srst_seq #(.SOFT_LEN(SOFT_LEN), .HARD_LEN(HARD_LEN), .BIST_LEN(BIST_LEN)) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start       (start_w),
    .start_hard  (hard_w),
    .start_selft (selft_w),
    .cpu_reset_n (cpu_reset_n),
    .cpu_init_n  (cpu_init_n),
    .busy        (busy)
  );

  // R3: a sequence begins only one cycle after an accepted request edge
  p_start_edge_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> $past(start_w));

  // R7: no sequence begins with deturbo enabled
  p_no_deturbo_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> !deturbo);
endmodule

// File: tb/srst_ctrl_test.sv
module srst_ctrl_test;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] PADDR = 16'h0C80;
  localparam int SOFT = 4;
  localparam int HARD = 8;
  localparam int BIST = 6;
  localparam int WIN  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] io_addr = PADDR;
  logic          io_wr = 1'b0;
  logic [7:0]    io_wdata = 8'h00;
  logic [7:0]    io_rdata;
  logic          cpu_reset_n, cpu_init_n, deturbo, busy;

  int total = 0;
  int bad = 0;
  int n_init = 0, n_rst = 0, n_only = 0, n_busy = 0;
  int b_init, b_rst, b_only, b_busy;

  always #4 clk = ~clk;

  srst_ctrl #(.ADDR_W(AW), .PORT_ADDR(PADDR), .SOFT_LEN(SOFT),
              .HARD_LEN(HARD), .BIST_LEN(BIST)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_reset_n(cpu_reset_n),
    .cpu_init_n(cpu_init_n), .deturbo(deturbo), .busy(busy));

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cpu_init_n) n_init++;
      if (!cpu_reset_n) n_rst++;
      if (!cpu_init_n && cpu_reset_n) n_only++;
      if (busy) n_busy++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = PADDR;
    #1;
  endtask

  task automatic snap();
    @(negedge clk); #1;
    b_init = n_init; b_rst = n_rst; b_only = n_only; b_busy = n_busy;
  endtask

  task automatic settle();
    repeat (WIN) @(negedge clk);
    #1;
  endtask

  task automatic expect_counts(input string req, input int ei, input int er,
                               input int eo, input int eb);
    check({req, " init cycles"}, n_init - b_init, ei);
    check({req, " reset cycles"}, n_rst - b_rst, er);
    check({req, " init-only cycles"}, n_only - b_only, eo);
    check({req, " busy cycles"}, n_busy - b_busy, eb);
  endtask

  task automatic t_reset_state();
    @(negedge clk); #1;
    check("R1 rdata", io_rdata, 0);
    check("R1 reset_n", cpu_reset_n, 1);
    check("R1 init_n", cpu_init_n, 1);
    check("R1 busy", busy, 0);
    check("R1 deturbo", deturbo, 0);
  endtask

  task automatic t_readback();
    io_write(PADDR, 8'hFA);
    check("R2 reserved bits read zero", io_rdata, 8'h0A);
    io_write(PADDR, 8'h03);
    check("R2 readback", io_rdata, 8'h03);
    check("R7 deturbo follows bit0", deturbo, 1);
    io_write(PADDR + 16'h1, 8'h00);
    check("R2 other-address write ignored", io_rdata, 8'h03);
    io_addr = PADDR + 16'h4; #1;
    check("R2 other-address read zero", io_rdata, 0);
    io_addr = PADDR; #1;
    io_write(PADDR, 8'h00);
    check("R7 deturbo cleared", deturbo, 0);
  endtask

  task automatic t_soft();
    io_write(PADDR, 8'h00);
    snap();
    io_write(PADDR, 8'h04);
    settle();
    expect_counts("R4 soft", SOFT, 0, SOFT, SOFT);
  endtask

  task automatic t_repeat();
    io_write(PADDR, 8'h00);
    io_write(PADDR, 8'h04);
    settle();
    snap();
    io_write(PADDR, 8'h04);
    io_write(PADDR, 8'h06);
    settle();
    expect_counts("R3 no edge", 0, 0, 0, 0);
  endtask

  task automatic t_hard();
    io_write(PADDR, 8'h00);
    io_write(PADDR, 8'h02);
    snap();
    io_write(PADDR, 8'h06);
    settle();
    expect_counts("R5 hard", 0, HARD, 0, HARD);
  endtask

  task automatic t_selftest();
    io_write(PADDR, 8'h00);
    snap();
    io_write(PADDR, 8'h0C);
    settle();
    expect_counts("R6 self-test", HARD + BIST, HARD, BIST, HARD + BIST);
  endtask

  task automatic t_deturbo();
    io_write(PADDR, 8'h00);
    io_write(PADDR, 8'h01);
    snap();
    io_write(PADDR, 8'h05);
    settle();
    expect_counts("R7 blocked", 0, 0, 0, 0);
    check("R7 deturbo out", deturbo, 1);
    io_write(PADDR, 8'h00);
    check("R7 deturbo off", deturbo, 0);
    snap();
    io_write(PADDR, 8'h04);
    settle();
    expect_counts("R7 edge after clear", SOFT, 0, SOFT, SOFT);
  endtask

  task automatic t_busy();
    io_write(PADDR, 8'h00);
    snap();
    io_write(PADDR, 8'h06);
    check("R8 busy after start", busy, 1);
    io_write(PADDR, 8'h00);
    io_write(PADDR, 8'h04);
    settle();
    expect_counts("R8 edge during busy", 0, HARD, 0, HARD);
    check("R8 busy idle", busy, 0);
  endtask

  task automatic t_capture();
    io_write(PADDR, 8'h00);
    snap();
    io_write(PADDR, 8'h04);
    io_write(PADDR, 8'h0E);
    settle();
    expect_counts("R9 mode captured", SOFT, 0, SOFT, SOFT);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_readback();
    t_soft();
    t_repeat();
    t_hard();
    t_selftest();
    t_deturbo();
    t_busy();
    t_capture();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule